// File: doc/BRIEF.md
# Latched Fault Flag and Recovery Controller

This block sits between the protection comparators of a six-half-bridge motor driver and the switch gate logic. It watches three fault sources (supply overvoltage, die overtemperature and one overcurrent comparator per switch), removes chatter from each of them, and keeps a sticky flag per fault class. The flags appear in the top three bits of the status word that a serial host reads back.

The block drives a force-off mask, one bit per switch, that the gate logic ANDs away from the commanded switch states. Overvoltage and overtemperature pull every switch off only while the filtered condition lasts. An overcurrent switch stays off until the host clears it.

The block also decodes each committed 16-bit host frame. The frame's clear bits act on the flags. The block then hands the control payload to the control register, or hands it all zeros when the frame asks for a full status reset.

Top module: `fault_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `force_off_o` all ones, `flags_o` zero, `ctrl_load_o` low and `ctrl_word_o` zero.
- R2: A raw detect level changes the internal filtered level only after it has differed from that level on FILT_LEN consecutive clock edges (default 16). A shorter excursion leaves flags and mask untouched.
- R3: While filtered overvoltage is high, every bit of `force_off_o` is set and `flags_o[2]` (status bit 15) is set. When the filtered level falls, the mask bits return to the overcurrent latches, but `flags_o[2]` stays set until it is cleared.
- R4: Filtered overtemperature forces all mask bits in the same way and sets `flags_o[1]` (status bit 14). The mask recovers by itself, and the flag stays set.
- R5: Filtered overcurrent on switch i sets `force_off_o[i]` and `flags_o[0]` (status bit 13). Both stay set after the current falls, until a clear.
- R6: A committed frame with bit 13 set clears the overcurrent latches and flag, bit 14 clears the overtemperature flag, and bit 15 clears the overvoltage flag. One cycle later, `ctrl_load_o` pulses with `ctrl_word_o` equal to frame bits 12..1.
- R7: A frame with bits 0 and 15 both set clears every flag and overcurrent latch. `ctrl_load_o` pulses with `ctrl_word_o` zero, so bits 12..1 of that frame are discarded.
- R8: A frame with bit 0 set and bit 15 clear leaves every flag as it was and loads bits 12..1 normally.
- R9: If a fault is still present in filtered form when its clear arrives, detection wins and the flag (and for overcurrent, the mask bit) stays set.
- R10: While `standby_i` is high, the filtered levels are held at zero, so no raw detect sets a flag or a mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| standby_i | input | 1 | Low-power mode, disables detection |
| ov_raw_i | input | 1 | Raw supply overvoltage comparator |
| ot_raw_i | input | 1 | Raw overtemperature comparator |
| oc_raw_i | input | N_SW | Raw per-switch overcurrent comparators |
| cmd_valid_i | input | 1 | One-cycle strobe of a committed host frame |
| cmd_i | input | N_SW+4 | Committed host frame |
| force_off_o | output | N_SW | Per-switch forced-off mask |
| flags_o | output | 3 | Sticky flags {overvoltage, overtemperature, overcurrent} |
| ctrl_load_o | output | 1 | Pulse: control register must load `ctrl_word_o` |
| ctrl_word_o | output | N_SW | Control payload, zero after a full reset frame |

## Verification
The bench goes after a clear arriving while the fault is still present. A design that let the clear win would drop the flag and re-enable a shorted switch for a cycle. It fires bit 0 without bit 15, which a loose decoder would treat as a full reset and so wipe the flags. It sends bursts one edge shorter than the filter window, which an off-by-one counter would pass through as a fault. It also lets overvoltage and overtemperature fall away, checking that the mask recovers while the flag stays, and it raises faults during standby, where a design that kept filtering would latch flags.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int FULL_LO_BIT = 0;

  typedef struct packed {
    logic ov;
    logic ot;
    logic oc;
  } flag_t;

  typedef struct packed {
    logic full;
    logic clr_ov;
    logic clr_ot;
    logic clr_oc;
  } cmd_act_t;
endpackage

// File: rtl/fg_deglitch.sv
module fg_deglitch #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_clr,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold_clr) begin
      filt_o <= 1'b0;
      cnt    <= '0;
    end else if (raw_i == filt_o) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      filt_o <= raw_i;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fg_decode.sv
module fg_decode
  import fault_pkg::*;
#(
  parameter int N_SW = 12,
  localparam int CMD_W = N_SW + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_act_t         act_o,
  output logic             ctrl_load_o,
  output logic [N_SW-1:0]  ctrl_word_o
);
  localparam int OC_BIT = N_SW + 1;
  localparam int OT_BIT = N_SW + 2;
  localparam int OV_BIT = N_SW + 3;

  always_comb begin
    act_o.full   = cmd_valid_i & cmd_i[FULL_LO_BIT] & cmd_i[OV_BIT];
    act_o.clr_ov = cmd_valid_i & cmd_i[OV_BIT];
    act_o.clr_ot = cmd_valid_i & (cmd_i[OT_BIT] | act_o.full);
    act_o.clr_oc = cmd_valid_i & (cmd_i[OC_BIT] | act_o.full);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_load_o <= 1'b0;
      ctrl_word_o <= '0;
    end else begin
      ctrl_load_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        ctrl_word_o <= act_o.full ? '0 : cmd_i[N_SW:1];
      end
    end
  end
endmodule

// File: rtl/fg_flags.sv
module fg_flags
  import fault_pkg::*;
#(
  parameter int N_SW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ov_f,
  input  logic            ot_f,
  input  logic [N_SW-1:0] oc_f,
  input  cmd_act_t        act_i,
  output flag_t           flags_o,
  output logic [N_SW-1:0] force_off_o
);
  logic [N_SW-1:0] oc_lat;
  logic [N_SW-1:0] oc_nxt;

  always_comb begin
    oc_nxt = oc_f | (oc_lat & ~{N_SW{act_i.clr_oc}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o     <= '0;
      oc_lat      <= '0;
      force_off_o <= '1;
    end else begin
      flags_o.ov  <= ov_f | (flags_o.ov & ~act_i.clr_ov);
      flags_o.ot  <= ot_f | (flags_o.ot & ~act_i.clr_ot);
      flags_o.oc  <= (|oc_f) | (flags_o.oc & ~act_i.clr_oc);
      oc_lat      <= oc_nxt;
      force_off_o <= {N_SW{ov_f | ot_f}} | oc_nxt;
    end
  end
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fault_pkg::*;
#(
  parameter int N_SW     = 12,
  parameter int FILT_LEN = 16,
  localparam int CMD_W   = N_SW + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             standby_i,
  input  logic             ov_raw_i,
  input  logic             ot_raw_i,
  input  logic [N_SW-1:0]  oc_raw_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic [N_SW-1:0]  force_off_o,
  output logic [2:0]       flags_o,
  output logic             ctrl_load_o,
  output logic [N_SW-1:0]  ctrl_word_o
);
  localparam int N_CH = N_SW + 2;

  logic [N_CH-1:0] raw_all;
  logic [N_CH-1:0] filt_all;
  cmd_act_t        act;
  flag_t           flags;

  assign raw_all = {oc_raw_i, ot_raw_i, ov_raw_i};

  for (genvar g = 0; g < N_CH; g++) begin : g_filt
    fg_deglitch #(.LEN(FILT_LEN)) u_dg (
      .clk      (clk),
      .rst      (rst),
      .hold_clr (standby_i),
      .raw_i    (raw_all[g]),
      .filt_o   (filt_all[g])
    );
  end

  fg_decode #(.N_SW(N_SW)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .act_o       (act),
    .ctrl_load_o (ctrl_load_o),
    .ctrl_word_o (ctrl_word_o)
  );

  fg_flags #(.N_SW(N_SW)) u_flg (
    .clk         (clk),
    .rst         (rst),
    .ov_f        (filt_all[0]),
    .ot_f        (filt_all[1]),
    .oc_f        (filt_all[N_CH-1:2]),
    .act_i       (act),
    .flags_o     (flags),
    .force_off_o (force_off_o)
  );

  assign flags_o = flags;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
  parameter int N_SW = 12,
  localparam int CMD_W = N_SW + 4
) (
  input logic             clk,
  input logic             rst,
  input logic             standby_i,
  input logic             cmd_valid_i,
  input logic [CMD_W-1:0] cmd_i,
  input logic [N_SW-1:0]  force_off_o,
  input logic [2:0]       flags_o,
  input logic             ctrl_load_o,
  input logic [N_SW-1:0]  ctrl_word_o
);
  localparam int OC_BIT = N_SW + 1;
  localparam int OT_BIT = N_SW + 2;
  localparam int OV_BIT = N_SW + 3;

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      AST_RESET_STATE: assert (force_off_o == '1 && flags_o == 3'b000 && !ctrl_load_o) // R1
        else $error("reset state wrong");
    end
  end

  AST_OV_FORCES_ALL: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_o[2]) |-> (force_off_o == '1)) // R3
    else $error("ov flag rose without full mask");

  AST_OV_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags_o[2] && !(cmd_valid_i && cmd_i[OV_BIT])) |=> flags_o[2]) // R3
    else $error("ov flag dropped without clear");

  AST_OT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags_o[1] && !(cmd_valid_i && (cmd_i[OT_BIT] || (cmd_i[0] && cmd_i[OV_BIT])))) |=> flags_o[1]) // R4
    else $error("ot flag dropped without clear");

  AST_OC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags_o[0] && !(cmd_valid_i && (cmd_i[OC_BIT] || (cmd_i[0] && cmd_i[OV_BIT])))) |=> flags_o[0]) // R5
    else $error("oc flag dropped without clear");

  AST_FULL_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_i[0] && cmd_i[OV_BIT]) |=> (ctrl_load_o && ctrl_word_o == '0)) // R7
    else $error("full reset frame loaded payload");

  AST_LONE_BIT0: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_i[0] && !cmd_i[OV_BIT]) |=> (ctrl_load_o && ctrl_word_o == $past(cmd_i[N_SW:1]))) // R8
    else $error("lone bit0 frame altered payload");

  AST_STANDBY_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (standby_i && $past(standby_i)) |=> ((flags_o & ~$past(flags_o)) == 3'b000)) // R10
    else $error("flag set during standby");
endmodule

bind fault_guard fault_guard_chk #(.N_SW(N_SW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .standby_i   (standby_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .force_off_o (force_off_o),
  .flags_o     (flags_o),
  .ctrl_load_o (ctrl_load_o),
  .ctrl_word_o (ctrl_word_o)
);

// File: tb/test_fault_guard.sv
module test_fault_guard;
  localparam int NS  = 12;
  localparam int FL  = 16;
  localparam int CW  = NS + 4;
  localparam int NCH = NS + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          standby = 1'b0;
  logic          ov_raw = 1'b0;
  logic          ot_raw = 1'b0;
  logic [NS-1:0] oc_raw = '0;
  logic          cvalid = 1'b0;
  logic [CW-1:0] cword = '0;
  logic [NS-1:0] force_off;
  logic [2:0]    flags;
  logic          ld;
  logic [NS-1:0] word;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  fault_guard #(.N_SW(NS), .FILT_LEN(FL)) i_fault_guard (
    .clk(clk), .rst(rst), .standby_i(standby), .ov_raw_i(ov_raw),
    .ot_raw_i(ot_raw), .oc_raw_i(oc_raw), .cmd_valid_i(cvalid),
    .cmd_i(cword), .force_off_o(force_off), .flags_o(flags),
    .ctrl_load_o(ld), .ctrl_word_o(word)
  );

  // reference model built from the requirements
  bit            m_f [NCH];
  int            m_c [NCH];
  bit            m_ov, m_ot, m_oc;
  logic [NS-1:0] m_lat, m_force, m_word;
  bit            m_ld;

  function automatic bit raw_of(int ch);
    if (ch == 0) return ov_raw;
    if (ch == 1) return ot_raw;
    return oc_raw[ch-2];
  endfunction

  always @(posedge clk) begin : model
    logic [NS-1:0] ocf, nxt;
    bit full, cov, cot, coc;
    started <= 1'b1;
    if (rst) begin
      m_ov = 0; m_ot = 0; m_oc = 0; m_lat = '0; m_force = '1;
      m_ld = 0; m_word = '0;
    end else begin
      for (int i = 0; i < NS; i++) ocf[i] = m_f[i+2];
      full = cvalid & cword[0] & cword[NS+3];
      cov  = cvalid & cword[NS+3];
      cot  = cvalid & (cword[NS+2] | full);
      coc  = cvalid & (cword[NS+1] | full);
      m_ov = m_f[0] | (m_ov & ~cov);
      m_ot = m_f[1] | (m_ot & ~cot);
      m_oc = (|ocf) | (m_oc & ~coc);
      nxt  = ocf | (m_lat & ~{NS{coc}});
      m_lat = nxt;
      m_force = {NS{m_f[0] | m_f[1]}} | nxt;
      m_ld = cvalid;
      if (cvalid) m_word = full ? '0 : cword[NS:1];
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (rst || standby) begin m_f[ch] = 0; m_c[ch] = 0; end
      else if (raw_of(ch) == m_f[ch]) m_c[ch] = 0;
      else if (m_c[ch] == FL - 1) begin m_f[ch] = raw_of(ch); m_c[ch] = 0; end
      else m_c[ch] = m_c[ch] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(flags[2] == m_ov, "R3", "model ov flag", 32'(flags[2]), 32'(m_ov));
      chk(flags[1] == m_ot, "R4", "model ot flag", 32'(flags[1]), 32'(m_ot));
      chk(flags[0] == m_oc, "R5", "model oc flag", 32'(flags[0]), 32'(m_oc));
      chk(force_off == m_force, "R5", "model mask", 32'(force_off), 32'(m_force));
      chk(ld == m_ld, "R6", "model load", 32'(ld), 32'(m_ld));
      chk(word == m_word, "R7", "model word", 32'(word), 32'(m_word));
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [CW-1:0] w);
    @(negedge clk); cvalid = 1'b1; cword = w;
    @(negedge clk); cvalid = 1'b0; cword = '0;
  endtask

  initial begin
    void'($urandom(32'd7031));
    wait_cyc(3);
    chk(force_off == '1 && flags == 0 && !ld && word == 0, "R1", "reset outputs",
        {force_off, flags, ld}, {12'hfff, 3'b0, 1'b0});
    rst = 1'b0;
    wait_cyc(2);

    // chatter shorter than the window
    oc_raw[3] = 1'b1; wait_cyc(FL - 1); oc_raw[3] = 1'b0; wait_cyc(FL + 4);
    chk(flags == 0 && force_off == 0, "R2", "short burst ignored", {force_off, flags}, 0);

    // sustained overcurrent on switch 3
    oc_raw[3] = 1'b1; wait_cyc(FL + 4); oc_raw[3] = 1'b0; wait_cyc(FL + 10);
    chk(flags == 3'b001, "R5", "oc flag held", flags, 3'b001);
    chk(force_off == 12'h008, "R5", "oc switch held off", force_off, 12'h008);

    send(16'h2000 | 16'h0aa6);
    chk(flags == 0 && force_off == 0, "R6", "oc clear", {force_off, flags}, 0);
    chk(ld && word == 12'h553, "R6", "payload loaded", {ld, word}, {1'b1, 12'h553});

    // overvoltage: self recovery of mask, flag sticky
    ov_raw = 1'b1; wait_cyc(FL + 4);
    chk(force_off == '1 && flags[2], "R3", "ov forces all", {force_off, flags}, {12'hfff, 3'b100});
    ov_raw = 1'b0; wait_cyc(FL + 4);
    chk(force_off == 0 && flags == 3'b100, "R3", "ov mask recovers", {force_off, flags}, 3'b100);

    ot_raw = 1'b1; wait_cyc(FL + 4);
    chk(force_off == '1 && flags == 3'b110, "R4", "ot forces all", {force_off, flags}, {12'hfff, 3'b110});
    ot_raw = 1'b0; wait_cyc(FL + 4);
    chk(force_off == 0 && flags == 3'b110, "R4", "ot mask recovers", {force_off, flags}, 3'b110);

    send(16'h0001 | 16'h0010);
    chk(flags == 3'b110, "R8", "bit0 alone keeps flags", flags, 3'b110);
    chk(ld && word == 12'h008, "R8", "bit0 alone loads payload", {ld, word}, {1'b1, 12'h008});

    send(16'h8001 | 16'h1ffe);
    chk(flags == 0, "R7", "full reset clears flags", flags, 0);
    chk(ld && word == 0, "R7", "full reset zero word", {ld, word}, {1'b1, 12'h000});

    // clear while fault still present
    ot_raw = 1'b1; oc_raw[7] = 1'b1; wait_cyc(FL + 4);
    send(16'h6000);
    chk(flags == 3'b011, "R9", "detection wins over clear", flags, 3'b011);
    chk(force_off == '1, "R9", "mask stays forced", force_off, 12'hfff);
    ot_raw = 1'b0; oc_raw[7] = 1'b0; wait_cyc(FL + 4);
    chk(force_off == 12'h080, "R9", "oc latch survives clear", force_off, 12'h080);
    send(16'h6000);
    chk(flags == 0 && force_off == 0, "R6", "clear after fault gone", {force_off, flags}, 0);

    // standby disables detection
    standby = 1'b1; ov_raw = 1'b1; oc_raw = 12'hfff; wait_cyc(3 * FL);
    chk(flags == 0 && force_off == 0, "R10", "standby ignores faults", {force_off, flags}, 0);
    ov_raw = 1'b0; oc_raw = '0; wait_cyc(2); standby = 1'b0; wait_cyc(2);

    // constrained random phase checked against the model
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 39) == 0) ov_raw = ~ov_raw;
      if ($urandom_range(0, 39) == 0) ot_raw = ~ot_raw;
      if ($urandom_range(0, 9) == 0) oc_raw[$urandom_range(0, NS - 1)] ^= 1'b1;
      if ($urandom_range(0, 299) == 0) standby = ~standby;
      if ($urandom_range(0, 199) == 0) rst = 1'b1; else rst = 1'b0;
      cvalid = ($urandom_range(0, 7) == 0);
      cword  = CW'($urandom);
      if ($urandom_range(0, 3) == 0) cword[0] = 1'b1;
    end
    @(negedge clk);
    cvalid = 1'b0; rst = 1'b0;
    wait_cyc(4);
    summary();
    $finish;
  end
endmodule